// File: doc/BRIEF.md
# SPI master serial shifter

This block is the synchronous-peripheral master mode of a serial transceiver. When the 4-bit mode selector holds 4'hE, a write to the transmit port starts one frame. The block pulls the slave-select line (carried on the transceiver's request-to-send pin) low. It then clocks out 5 to 9 data bits, most significant first, on the transmit-data pin, and shifts in the same number of bits from the receive-data pin. When the frame ends it releases slave select and presents the received word with a one-cycle valid pulse. There are no start, parity or stop bits.

The serial clock is built from the system clock. The clock source is either the system clock itself or the system clock pre-divided by `PREDIV`. A programmable divisor sets how many source steps make up one bit period. Divisors below 6 are clamped to 6. On the pre-divided source the divisor is rounded down to an even value, so the duty cycle stays at 50:50. The polarity and phase settings choose which clock edges launch and which capture data.

The mode code is shared with the other transceiver modes. After the first frame, any change of that code locks the transmitter until a software reset is issued.

Top module: `spim_master`

## Requirements
- R1: `tx_ready` is high only while no frame is running, `cfg_mode` equals 4'hE and no software reset is pending. A `tx_wr` while `tx_ready` is low is ignored, and `rts` stays high.
- R2: A write accepted at a clock edge drives `rts` low from that edge for exactly S*D*(N+2) cycles. Here S is the source step length in cycles, D the effective divisor and N the bit count. The time is one D-step lead-in, N bit periods and one D-step tail. `rts` is high otherwise.
- R3: `txd` is high while idle. During the lead-in and bit k (k counted from 0), `txd` carries data bit N-1-k, so the MSB goes first. During the tail `txd` is low.
- R4: `cfg_len` values 2'b00, 2'b01, 2'b10 and 2'b11 give N = 5, 6, 7 and 8. `cfg_nine` = 1 gives N = 9 whatever `cfg_len` holds.
- R5: A `cfg_div` value below 6 acts as 6.
- R6: With `cfg_srcdiv` = 0, S = 1 and an odd divisor is used as is. With `cfg_srcdiv` = 1, S = `PREDIV` and the divisor's LSB is cleared after the clamp.
- R7: Within each bit period, `sck` equals CPOL xor CPHA for the first floor(D/2) steps and the inverse for the rest. During the lead-in and the tail, `sck` equals CPOL.
- R8: `rxd` is sampled at the mid-bit clock transition of each bit, first sample as MSB. At the end of the frame, `rx_data` holds the N samples in its low bits with the upper bits zero, and `rx_valid` is high for exactly that one cycle.
- R9: After the first frame, any change of `cfg_mode` holds `tx_ready` low until `soft_rst`. A `soft_rst` also aborts a running frame and returns `rts` high at the next edge.
- R10: While idle, `sck` follows `cfg_cpol` one cycle later.
- R11: If `cfg_mode` leaves 4'hE during a frame, the frame stops and `rts` goes high at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_mode | input | 4 | transceiver mode selector, 4'hE selects this master |
| cfg_cpol | input | 1 | serial clock idle level |
| cfg_cpha | input | 1 | clock phase select |
| cfg_len | input | 2 | character length code |
| cfg_nine | input | 1 | force nine-bit characters |
| cfg_div | input | DIV_W | clock divisor |
| cfg_srcdiv | input | 1 | 1: pre-divided source, 0: system clock |
| soft_rst | input | 1 | software reset of transmitter and receiver |
| tx_data | input | 9 | word to send, low N bits used |
| tx_wr | input | 1 | write strobe for tx_data |
| tx_ready | output | 1 | a write will be accepted |
| txd | output | 1 | serial data out (MOSI) |
| rxd | input | 1 | serial data in (MISO) |
| sck | output | 1 | serial clock |
| rts | output | 1 | active-low slave select |
| rx_data | output | 9 | last received word |
| rx_valid | output | 1 | one-cycle pulse when rx_data is updated |

## Verification
Frames are sent in all four polarity/phase combinations. A behavioural model compares `sck`, `txd`, `rts`, `tx_ready` and the received word every cycle, so a swapped launch edge or a wrong sampling point shows up at once. Each length code and the nine-bit override are tried; since each gives a different bit count, a wrong length decode changes the frame duration. The divisor is tried below the minimum, odd on the system clock, and odd and even on the pre-divided source, which separates the clamp, the even rounding and the source step. Mid-frame mode exit, mode change followed by a blocked write, and software reset show the abort path and the reset lock.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_BITS  = 2'd2,
    ST_TRAIL = 2'd3
  } spim_state_e;

  localparam logic [3:0] MODE_SPIM = 4'hE;
  localparam int         SPIM_DW   = 9;
  localparam int         DIV_MIN   = 6;

  function automatic logic [3:0] spim_nbits(input logic [1:0] len, input logic nine);
    return nine ? 4'd9 : (4'd5 + {2'b00, len});
  endfunction

endpackage

// File: rtl/spim_prescale.sv
module spim_prescale #(
  parameter int PREDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic use_div,
  output logic tick
);
  localparam int PW = (PREDIV > 1) ? $clog2(PREDIV) : 1;
  localparam logic [PW-1:0] PC_LAST = PW'(PREDIV - 1);

  logic [PW-1:0] pc_q, pc_n;
  logic          wrap;

  assign wrap = (pc_q == PC_LAST);
  assign tick = run && (!use_div || wrap);

  always_comb begin
    if (!run || wrap) pc_n = '0;
    else              pc_n = pc_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_n;
  end

endmodule

// File: rtl/spim_core.sv
module spim_core
  import spim_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               abort,
  input  logic               start,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic [1:0]         cfg_len,
  input  logic               cfg_nine,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic               cfg_srcdiv,
  input  logic [SPIM_DW-1:0] tx_data,
  input  logic               tick,
  input  logic               rxd,
  output logic               idle,
  output logic               src_sel,
  output logic               sck,
  output logic               ss_n,
  output logic               txd,
  output logic [SPIM_DW-1:0] rx_data,
  output logic               rx_valid
);
  spim_state_e        state_q, state_n;
  logic [DIV_W-1:0]   tcnt_q, tcnt_n, eff_q, eff_n, half_q, half_n, eff_in;
  logic [3:0]         bcnt_q, bcnt_n, nb_q, nb_n, nb_in;
  logic               lead_q, lead_n, cpol_q, cpol_n, src_q, src_n;
  logic [SPIM_DW-1:0] tsh_q, tsh_n, rsh_q, rsh_n, rxw_q, rxw_n;
  logic               sck_q, sck_n, ss_q, ss_nx, rxv_q, rxv_n;
  logic               at_end, at_mid;

  assign at_end = tick && (tcnt_q == eff_q - DIV_W'(1));
  assign at_mid = tick && (tcnt_q == half_q - DIV_W'(1));
  assign nb_in  = spim_nbits(cfg_len, cfg_nine);

  always_comb begin
    eff_in = (cfg_div < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : cfg_div;
    if (cfg_srcdiv) eff_in[0] = 1'b0;
  end

  // next-state logic
  always_comb begin
    state_n = state_q;  tcnt_n = tcnt_q;  bcnt_n = bcnt_q;  nb_n = nb_q;
    eff_n   = eff_q;    half_n = half_q;  lead_n = lead_q;  cpol_n = cpol_q;
    src_n   = src_q;    tsh_n  = tsh_q;   rsh_n  = rsh_q;   rxw_n  = rxw_q;
    rxv_n   = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_n = ST_LEAD;
        tcnt_n  = '0;
        bcnt_n  = '0;
        nb_n    = nb_in;
        eff_n   = eff_in;
        half_n  = eff_in >> 1;
        lead_n  = cfg_cpol ^ cfg_cpha;
        cpol_n  = cfg_cpol;
        src_n   = cfg_srcdiv;
        tsh_n   = tx_data << (4'(SPIM_DW) - nb_in);
        rsh_n   = '0;
      end
      ST_LEAD: if (tick) begin
        tcnt_n = at_end ? '0 : tcnt_q + DIV_W'(1);
        if (at_end) state_n = ST_BITS;
      end
      ST_BITS: if (tick) begin
        if (at_mid) rsh_n = {rsh_q[SPIM_DW-2:0], rxd};
        if (at_end) begin
          tcnt_n = '0;
          tsh_n  = {tsh_q[SPIM_DW-2:0], 1'b0};
          if (bcnt_q == nb_q - 4'd1) state_n = ST_TRAIL;
          else                       bcnt_n  = bcnt_q + 4'd1;
        end else begin
          tcnt_n = tcnt_q + DIV_W'(1);
        end
      end
      default: if (tick) begin
        tcnt_n = at_end ? '0 : tcnt_q + DIV_W'(1);
        if (at_end) begin
          state_n = ST_IDLE;
          rxw_n   = rsh_q;
          rxv_n   = 1'b1;
        end
      end
    endcase
    if (abort) begin
      state_n = ST_IDLE;
      rxv_n   = 1'b0;
      rxw_n   = rxw_q;
    end
    if (state_n == ST_BITS)      sck_n = (tcnt_n < half_q) ? lead_n : ~lead_n;
    else if (state_n == ST_IDLE) sck_n = cfg_cpol;
    else                         sck_n = cpol_n;
    ss_nx = (state_n == ST_IDLE);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  tcnt_q <= '0;  bcnt_q <= '0;  nb_q <= 4'd8;
      eff_q   <= DIV_W'(DIV_MIN);  half_q <= DIV_W'(DIV_MIN / 2);
      lead_q  <= 1'b0;  cpol_q <= 1'b0;  src_q <= 1'b0;
      tsh_q   <= '0;  rsh_q <= '0;  rxw_q <= '0;
      sck_q   <= 1'b0;  ss_q <= 1'b1;  rxv_q <= 1'b0;
    end else begin
      state_q <= state_n;  tcnt_q <= tcnt_n;  bcnt_q <= bcnt_n;  nb_q <= nb_n;
      eff_q   <= eff_n;    half_q <= half_n;
      lead_q  <= lead_n;   cpol_q <= cpol_n;  src_q <= src_n;
      tsh_q   <= tsh_n;    rsh_q  <= rsh_n;   rxw_q <= rxw_n;
      sck_q   <= sck_n;    ss_q   <= ss_nx;   rxv_q <= rxv_n;
    end
  end

  assign idle     = (state_q == ST_IDLE);
  assign src_sel  = src_q;
  assign sck      = sck_q;
  assign ss_n     = ss_q;
  assign txd      = (state_q == ST_IDLE) ? 1'b1 : tsh_q[SPIM_DW-1];
  assign rx_data  = rxw_q;
  assign rx_valid = rxv_q;

  AST_DIV_MIN:   assert property (@(posedge clk) disable iff (!rst_n)
                   (state_q != ST_IDLE) |-> (eff_q >= DIV_W'(DIV_MIN))); // R5
  AST_DIV_EVEN:  assert property (@(posedge clk) disable iff (!rst_n)
                   (state_q != ST_IDLE && src_q) |-> !eff_q[0]); // R6
  AST_SCK_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
                   (state_q == ST_LEAD || state_q == ST_TRAIL) |-> (sck_q == cpol_q)); // R7
  AST_SCK_IDLE:  assert property (@(posedge clk) disable iff (!rst_n)
                   ($past(rst_n) && state_q == ST_IDLE && $past(state_q) == ST_IDLE)
                   |-> (sck_q == $past(cfg_cpol))); // R10
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                   (state_q == ST_BITS) |-> (bcnt_q < nb_q)); // R2
  AST_RXV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
                   rxv_q |=> !rxv_q); // R8

endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int PREDIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         cfg_mode,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic [1:0]         cfg_len,
  input  logic               cfg_nine,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic               cfg_srcdiv,
  input  logic               soft_rst,
  input  logic [8:0]         tx_data,
  input  logic               tx_wr,
  output logic               tx_ready,
  output logic               txd,
  input  logic               rxd,
  output logic               sck,
  output logic               rts,
  output logic [8:0]         rx_data,
  output logic               rx_valid
);
  logic [3:0] mode_q;
  logic       armed_q, armed_n, need_q, need_n;
  logic       is_spim, core_idle, src_sel, tick, start, abort;

  assign is_spim  = (cfg_mode == MODE_SPIM);
  assign tx_ready = core_idle && is_spim && !need_q;
  assign start    = tx_wr && tx_ready && !soft_rst;
  assign abort    = soft_rst || !is_spim;

  always_comb begin
    armed_n = armed_q || start;
    if (soft_rst)                             need_n = 1'b0;
    else if (armed_q && (cfg_mode != mode_q)) need_n = 1'b1;
    else                                      need_n = need_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 4'h0;
      armed_q <= 1'b0;
      need_q  <= 1'b0;
    end else begin
      mode_q  <= cfg_mode;
      armed_q <= armed_n;
      need_q  <= need_n;
    end
  end

  spim_prescale #(.PREDIV(PREDIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(!core_idle), .use_div(src_sel), .tick(tick)
  );

  spim_core #(.DIV_W(DIV_W)) u_core (
    .clk(clk), .rst_n(rst_n), .abort(abort), .start(start),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_len(cfg_len), .cfg_nine(cfg_nine),
    .cfg_div(cfg_div), .cfg_srcdiv(cfg_srcdiv), .tx_data(tx_data), .tick(tick),
    .rxd(rxd), .idle(core_idle), .src_sel(src_sel), .sck(sck), .ss_n(rts),
    .txd(txd), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  AST_READY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
                    tx_ready |-> (cfg_mode == MODE_SPIM)); // R1
  AST_NEED_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
                    need_q |-> !tx_ready); // R9
  AST_MODE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
                    (!core_idle && !is_spim) |=> (core_idle && rts)); // R11

endmodule

// File: tb/spim_master_test.sv
module spim_master_test;
  localparam int PREDIV = 4;

  logic       clk, rst_n;
  logic [3:0] cfg_mode;
  logic       cfg_cpol, cfg_cpha, cfg_nine, cfg_srcdiv, soft_rst, tx_wr, rxd;
  logic [1:0] cfg_len;
  logic [7:0] cfg_div;
  logic [8:0] tx_data, rx_data;
  logic       tx_ready, txd, sck, rts, rx_valid;

  int n_cmp, n_bad;

  spim_master #(.DIV_W(8), .PREDIV(PREDIV)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_len(cfg_len), .cfg_nine(cfg_nine), .cfg_div(cfg_div), .cfg_srcdiv(cfg_srcdiv),
    .soft_rst(soft_rst), .tx_data(tx_data), .tx_wr(tx_wr), .tx_ready(tx_ready),
    .txd(txd), .rxd(rxd), .sck(sck), .rts(rts), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference model state
  int   m_busy, m_need, m_armed, m_e, m_eff, m_s, m_n, m_h1;
  int   m_rx, m_rxd, m_rxv, m_tx;
  logic m_cpol, m_cpha, m_sckidle, m_st;
  logic [3:0] m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_need = 0; m_armed = 0; m_e = 0; m_rx = 0; m_rxd = 0; m_rxv = 0;
      m_sckidle = 1'b0; m_prev = 4'h0; m_eff = 6; m_s = 1; m_n = 8; m_h1 = 3;
      m_tx = 0; m_cpol = 1'b0; m_cpha = 1'b0;
    end else begin
      m_rxv = 0;
      m_st = (m_busy == 0) && (cfg_mode == 4'hE) && (m_need == 0) && tx_wr && !soft_rst;
      if (soft_rst) m_need = 0;
      else if (m_armed != 0 && cfg_mode != m_prev) m_need = 1;
      m_prev = cfg_mode;
      if (m_st) m_armed = 1;
      m_sckidle = cfg_cpol;
      if (soft_rst || cfg_mode != 4'hE) begin
        m_busy = 0;
      end else if (m_busy != 0) begin
        m_e = m_e + 1;
        if (m_e % m_s == 0) begin
          int k;
          k = m_e / m_s;
          if (k >= m_eff && k < m_eff * (1 + m_n) && ((k - m_eff) % m_eff) == m_h1)
            m_rx = (m_rx << 1) | int'(rxd);
          if (k == m_eff * (2 + m_n)) begin
            m_busy = 0; m_rxv = 1; m_rxd = m_rx;
          end
        end
      end else if (m_st) begin
        m_busy = 1; m_e = 0; m_rx = 0;
        m_n   = cfg_nine ? 9 : 5 + int'(cfg_len);
        m_eff = (int'(cfg_div) < 6) ? 6 : int'(cfg_div);
        if (cfg_srcdiv) m_eff = m_eff & ~1;
        m_h1  = m_eff / 2;
        m_s   = cfg_srcdiv ? PREDIV : 1;
        m_cpol = cfg_cpol; m_cpha = cfg_cpha; m_tx = int'(tx_data);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_sck, e_rts, e_txd, e_rdy;
      e_rdy = (m_busy == 0) && (cfg_mode == 4'hE) && (m_need == 0);
      if (m_busy == 0) begin
        e_sck = m_sckidle; e_rts = 1'b1; e_txd = 1'b1;
      end else begin
        int k;
        k = m_e / m_s;
        e_rts = 1'b0;
        if (k < m_eff) begin
          e_sck = m_cpol; e_txd = 1'((m_tx >> (m_n - 1)) & 1);
        end else if (k < m_eff * (1 + m_n)) begin
          int i, pos;
          i = (k - m_eff) / m_eff; pos = (k - m_eff) % m_eff;
          e_sck = (pos < m_h1) ? (m_cpol ^ m_cpha) : ~(m_cpol ^ m_cpha);
          e_txd = 1'((m_tx >> (m_n - 1 - i)) & 1);
        end else begin
          e_sck = m_cpol; e_txd = 1'b0;
        end
      end
      chk("R7 R10 sck", int'(sck), int'(e_sck));
      chk("R2 rts", int'(rts), int'(e_rts));
      chk("R3 txd", int'(txd), int'(e_txd));
      chk("R1 R9 tx_ready", int'(tx_ready), int'(e_rdy));
      chk("R8 rx_valid", int'(rx_valid), m_rxv);
      chk("R8 rx_data", int'(rx_data), m_rxd);
    end
  end

  // serial input stimulus
  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    rxd = 1'b0;
    forever begin
      @(posedge clk); #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rxd = lf[0];
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic cfg(input logic pol, input logic pha, input logic [1:0] len, input logic nine,
                     input logic [7:0] div, input logic src);
    @(posedge clk); #1;
    cfg_cpol = pol; cfg_cpha = pha; cfg_len = len; cfg_nine = nine;
    cfg_div = div; cfg_srcdiv = src;
  endtask

  task automatic send(input logic [8:0] d, input int exp_cyc, input string tag);
    int n;
    n = 0;
    @(posedge clk); #1; tx_data = d; tx_wr = 1'b1;
    @(posedge clk); #1; tx_wr = 1'b0;
    @(negedge clk);
    while (rts == 1'b0 && n < 20000) begin
      n++;
      @(negedge clk);
    end
    chk(tag, n, exp_cyc);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; cfg_mode = 4'hE; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_len = 2'b11;
    cfg_nine = 1'b0; cfg_div = 8'd8; cfg_srcdiv = 1'b0; soft_rst = 1'b0;
    tx_data = '0; tx_wr = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset tx_ready", int'(tx_ready), 1);
    chk("R2 reset rts", int'(rts), 1);
    chk("R8 reset rx_valid", int'(rx_valid), 0);

    cfg(1'b0, 1'b0, 2'b11, 1'b0, 8'd8, 1'b0);
    send(9'h0A5, 8 * 10, "R2 len8 frame cycles");
    cfg(1'b0, 1'b1, 2'b00, 1'b0, 8'd8, 1'b0);
    send(9'h013, 8 * 7, "R4 len5 frame cycles");
    cfg(1'b1, 1'b1, 2'b01, 1'b0, 8'd8, 1'b0);
    send(9'h02D, 8 * 8, "R4 len6 frame cycles");
    cfg(1'b1, 1'b0, 2'b10, 1'b0, 8'd8, 1'b0);
    send(9'h05A, 8 * 9, "R4 len7 frame cycles");
    cfg(1'b0, 1'b0, 2'b00, 1'b1, 8'd8, 1'b0);
    send(9'h1A5, 8 * 11, "R4 nine-bit override cycles");
    cfg(1'b0, 1'b1, 2'b11, 1'b0, 8'd2, 1'b0);
    send(9'h0C3, 6 * 10, "R5 divisor clamp cycles");
    cfg(1'b1, 1'b0, 2'b11, 1'b0, 8'd0, 1'b0);
    send(9'h081, 6 * 10, "R5 zero divisor cycles");
    cfg(1'b0, 1'b0, 2'b11, 1'b0, 8'd7, 1'b0);
    send(9'h0F0, 7 * 10, "R6 odd divisor undivided cycles");
    cfg(1'b1, 1'b1, 2'b11, 1'b0, 8'd7, 1'b1);
    send(9'h03C, PREDIV * 6 * 10, "R6 odd divisor predivided cycles");
    cfg(0, 1'b1, 2'b00, 1'b0, 8'd10, 1'b1);
    send(9'h015, PREDIV * 10 * 7, "R6 even divisor predivided cycles");

    // R10: idle clock level follows polarity
    @(posedge clk); #1 cfg_cpol = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10 idle sck high", int'(sck), 1);
    @(posedge clk); #1 cfg_cpol = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 idle sck low", int'(sck), 0);

    // R11: mode leaves master mid-frame
    cfg(1'b0, 1'b0, 2'b11, 1'b0, 8'd8, 1'b0);
    @(posedge clk); #1 tx_data = 9'h0FF; tx_wr = 1'b1;
    @(posedge clk); #1 tx_wr = 1'b0;
    repeat (20) @(posedge clk);
    #1 cfg_mode = 4'h0;
    @(posedge clk); @(negedge clk);
    chk("R11 rts released on mode exit", int'(rts), 1);
    chk("R1 tx_ready low outside master mode", int'(tx_ready), 0);
    @(posedge clk); #1 cfg_mode = 4'hE;
    @(posedge clk); @(negedge clk);
    chk("R9 tx_ready locked after mode change", int'(tx_ready), 0);
    @(posedge clk); #1 tx_wr = 1'b1;
    @(posedge clk); #1 tx_wr = 1'b0;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      chk("R9 write ignored while locked", int'(rts), 1);
    end
    @(posedge clk); #1 soft_rst = 1'b1;
    @(posedge clk); #1 soft_rst = 1'b0;
    @(negedge clk);
    chk("R9 tx_ready after soft reset", int'(tx_ready), 1);

    // R9: software reset aborts a frame
    @(posedge clk); #1 tx_data = 9'h055; tx_wr = 1'b1;
    @(posedge clk); #1 tx_wr = 1'b0;
    repeat (15) @(posedge clk);
    #1 soft_rst = 1'b1;
    @(posedge clk); #1 soft_rst = 1'b0;
    @(negedge clk);
    chk("R9 rts released by soft reset", int'(rts), 1);

    send(9'h0B6, 8 * 10, "R8 frame after abort cycles");

    repeat (5) @(posedge clk);
    summary();
    $finish;
  end

endmodule